// File: doc/BRIEF.md
# ADC Controller Register Front-End

This block is the register-side controller of a three-engine analog-to-digital converter. A processor reaches it through a simple 32-bit register bus with a write strobe, a read strobe, an address and write data. Software starts a conversion on the auxiliary, battery or touch engine by setting that engine's start bit. The block runs a behavioural converter model for a fixed number of cycles. When the conversion completes, the block latches the 12-bit result and clears the start bit, so the start bit also serves as the busy flag that software polls.

Each completion, and each of four externally signalled touch and sleep events, raises a bit in a status register that software clears by writing ones. An interrupt mask holds back any source. The single interrupt output is registered. A power-down control aborts every pending start and keeps the converter idle. A config field picks which of two auxiliary inputs the auxiliary engine samples, so only one auxiliary input is converted at a time.

Top module: `adc_regfront`

## Requirements
- R1: After reset the enable register, the config register, the status register, both data registers and `irq_o` are all zero, and the mask register reads 0xFF.
- R2: The enable register is at offset 0x00, config at 0x04, mask at 0x08, status at 0x0C, battery data at 0x1C and auxiliary data at 0x20. The config register reads back all 32 written bits and the mask register reads back its low 8 bits. Any other offset reads zero and ignores writes. Read data appears on `bus_rdata_o` on the clock edge that samples `bus_rd_i`.
- R3: Writing the enable register loads its start bits (bit 0 auxiliary, bit 1 battery, bit 2 touch). A started engine stays busy, with its start bit reading 1, for CONV_LAT cycles.
- R4: The block clears an engine's start bit on the clock edge that completes that engine's conversion, which is CONV_LAT edges after the write that set it.
- R5: A completion sets status bit 0 (auxiliary), bit 1 (battery) or bit 2 (touch). Pulses on `evt_i[0]`, `evt_i[1]`, `evt_i[2]` and `evt_i[3]` set status bits 3 (pen down), 4 (pen up), 5 (pen down while asleep) and 7 (sleep). Status bit 6 always reads 0.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a bit's source fires in the same cycle as the clearing write, the bit stays set.
- R7: `irq_o` is the OR over all bits of status AND NOT mask, registered, so it follows a change in status or mask by one cycle. A mask of 0xFF keeps `irq_o` low.
- R8: When the auxiliary conversion completes, the auxiliary data register bits [11:0] take `aux_b_i` if config bits [1:0] equal 2'b10, and `aux_a_i` for any other value. Bits [31:12] read 0.
- R9: When the battery conversion completes, the battery data register bits [11:0] take `bat_i`. Bits [31:12] read 0.
- R10: Enable bit 7 is power-down. While it is set, all start bits read 0, and a write that sets start bits together with bit 7 starts nothing. Setting power-down during a conversion aborts it: no status bit is set and no data register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| aux_a_i | input | RES_W | First auxiliary input sample |
| aux_b_i | input | RES_W | Second auxiliary input sample |
| bat_i | input | RES_W | Battery input sample |
| evt_i | input | 4 | Pen-down, pen-up, pen-down-asleep and sleep event pulses |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench times the end of a conversion to the exact cycle. A design that cleared the busy bit one cycle early or late, or restarted the engine after completion, fails the check that reads busy just before the finishing edge and idle just after it. It also lands a status clear on the very edge where a completion arrives. A design that gave the clear priority would lose that completion.

The bench starts a conversion and then asserts power-down, and separately requests a start together with power-down. A design with a leaky abort would show a status bit or a changed data register. Random runs vary the auxiliary select code and the input values, and catch a select decoder that treats codes other than 2'b10 wrongly.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;
  // register byte offsets (software-visible map)
  localparam int OFS_EN   = 'h00;
  localparam int OFS_CFG  = 'h04;
  localparam int OFS_MASK = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_BDAT = 'h1C;
  localparam int OFS_ADAT = 'h20;

  // engine indices: start bit and status bit positions
  localparam int ENG_AUX = 0;
  localparam int ENG_BAT = 1;
  localparam int ENG_TCH = 2;
  localparam int NUM_ENG = 3;

  localparam int PD_BIT = 7;

  // event-driven status bits
  localparam int NUM_EVT = 4;
  localparam int STAT_W  = 8;
  localparam int EVT_POS [NUM_EVT] = '{3, 4, 5, 7};

  // config select code for the second auxiliary input
  localparam logic [1:0] AUXSEL_B = 2'b10;
endpackage

// File: rtl/adc_rf_conv.sv
module adc_rf_conv #(
  parameter int N_ENG = 3,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ENG-1:0] start_i,
  output logic [N_ENG-1:0] done_o
);
  localparam int CW = $clog2(LAT + 1);

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                          cnt <= '0;
      else if (!start_i[g] || done_o[g]) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
    // completion handshake: last busy cycle of this engine
    assign done_o[g] = start_i[g] && (cnt == CW'(LAT - 1));
  end
endmodule

// File: rtl/adc_rf_stat.sv
module adc_rf_stat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      mask_o   <= '1;
      irq_o    <= 1'b0;
    end else begin
      // a new event outranks a simultaneous clear
      status_o <= (status_o & ~clr_bits) | set_i;
      if (mask_wr_i) mask_o <= wdata_i;
      irq_o    <= |(status_o & ~mask_o);
    end
  end
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
  import adc_rf_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int RES_W    = 12,
  parameter int CONV_LAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [RES_W-1:0]  aux_a_i,
  input  logic [RES_W-1:0]  aux_b_i,
  input  logic [RES_W-1:0]  bat_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - RES_W;

  logic               en_wr, cfg_wr, mask_wr, stat_wr;
  logic [NUM_ENG-1:0] start_q, start_nx, conv_done, eff_done;
  logic               pd_q, pd_nx;
  logic [DATA_W-1:0]  cfg_q;
  logic [RES_W-1:0]   adat_q, bdat_q;
  logic [STAT_W-1:0]  stat_set, stat_q, mask_q;
  logic [DATA_W-1:0]  en_view;

  // address decode
  assign en_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_EN));
  assign cfg_wr  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CFG));
  assign mask_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK));
  assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT));

  // start bits: software write, hardware clear on completion, power-down abort
  always_comb begin
    pd_nx    = en_wr ? bus_wdata_i[PD_BIT] : pd_q;
    start_nx = en_wr ? bus_wdata_i[NUM_ENG-1:0] : (start_q & ~conv_done);
    if (pd_nx) start_nx = '0;
    eff_done = pd_nx ? '0 : conv_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      pd_q    <= 1'b0;
      cfg_q   <= '0;
    end else begin
      start_q <= start_nx;
      pd_q    <= pd_nx;
      if (cfg_wr) cfg_q <= bus_wdata_i;
    end
  end

  adc_rf_conv #(.N_ENG(NUM_ENG), .LAT(CONV_LAT)) conv_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_q),
    .done_o  (conv_done)
  );

  // result capture
  always_ff @(posedge clk) begin
    if (rst) begin
      adat_q <= '0;
      bdat_q <= '0;
    end else begin
      if (eff_done[ENG_AUX])
        adat_q <= (cfg_q[1:0] == AUXSEL_B) ? aux_b_i : aux_a_i;
      if (eff_done[ENG_BAT])
        bdat_q <= bat_i;
    end
  end

  // status sources
  always_comb begin
    stat_set = '0;
    stat_set[NUM_ENG-1:0] = eff_done;
    for (int k = 0; k < NUM_EVT; k++)
      stat_set[EVT_POS[k]] = evt_i[k];
  end

  adc_rf_stat #(.W(STAT_W)) stat_i (
    .clk       (clk),
    .rst       (rst),
    .set_i     (stat_set),
    .clr_wr_i  (stat_wr),
    .mask_wr_i (mask_wr),
    .wdata_i   (bus_wdata_i[STAT_W-1:0]),
    .status_o  (stat_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );

  // read path
  always_comb begin
    en_view = '0;
    en_view[NUM_ENG-1:0] = start_q;
    en_view[PD_BIT] = pd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        ADDR_W'(OFS_EN):   bus_rdata_o <= en_view;
        ADDR_W'(OFS_CFG):  bus_rdata_o <= cfg_q;
        ADDR_W'(OFS_MASK): bus_rdata_o <= DATA_W'(mask_q);
        ADDR_W'(OFS_STAT): bus_rdata_o <= DATA_W'(stat_q);
        ADDR_W'(OFS_BDAT): bus_rdata_o <= {{PAD_W{1'b0}}, bdat_q};
        ADDR_W'(OFS_ADAT): bus_rdata_o <= {{PAD_W{1'b0}}, adat_q};
        default:           bus_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_regfront_chk.sv
module adc_regfront_chk
  import adc_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [NUM_ENG-1:0] start_q,
  input logic               pd_q,
  input logic [NUM_ENG-1:0] conv_done,
  input logic [NUM_ENG-1:0] eff_done,
  input logic [STAT_W-1:0]  stat_q,
  input logic [STAT_W-1:0]  mask_q,
  input logic               irq_o
);
  logic en_wr_c, stat_wr_c;
  assign en_wr_c   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_EN));
  assign stat_wr_c = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT));

  a_r3_done_needs_start: assert property (@(posedge clk) disable iff (rst)
    (conv_done & ~start_q) == '0);

  a_r4_done_clears_start: assert property (@(posedge clk) disable iff (rst)
    (|eff_done && !en_wr_c) |=> ((start_q & $past(eff_done)) == '0));

  a_r5_done_sets_status: assert property (@(posedge clk) disable iff (rst)
    |eff_done |=> ((stat_q[NUM_ENG-1:0] & $past(eff_done)) == $past(eff_done)));

  a_r6_w1c_aux: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_c && bus_wdata_i[ENG_AUX] && !eff_done[ENG_AUX]) |=> !stat_q[ENG_AUX]);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(stat_q) & ~$past(mask_q))));

  a_r10_pd_idle: assert property (@(posedge clk) disable iff (rst)
    pd_q |-> (start_q == '0 && conv_done == '0));
endmodule

bind adc_regfront adc_regfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .start_q     (start_q),
  .pd_q        (pd_q),
  .conv_done   (conv_done),
  .eff_done    (eff_done),
  .stat_q      (stat_q),
  .mask_q      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/adc_regfront_tb.sv
module adc_regfront_tb_top;
  localparam int AW  = 6;
  localparam int DW  = 32;
  localparam int RW  = 12;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [RW-1:0] aux_a = '0, aux_b = '0, bat = '0;
  logic [3:0]    evt = '0;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_regfront #(.ADDR_W(AW), .DATA_W(DW), .RES_W(RW), .CONV_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .aux_a_i(aux_a), .aux_b_i(aux_b),
    .bat_i(bat), .evt_i(evt), .irq_o(irq)
  );

  function automatic logic [31:0] exp_aux(input logic [1:0] sel,
                                          input logic [11:0] a, input logic [11:0] b);
    return {20'h0, (sel == 2'b10) ? b : a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; the access takes effect on the next rising edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle(input int eng, output int reads);
    logic [31:0] v;
    reads = 0;
    do begin
      bus_rd(6'h00, v);
      reads++;
    end while (v[eng] && reads < 4 * LAT);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] last_aux;
    int n;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    bus_rd(6'h00, v); chk("R1 enable", v, 32'h0);
    bus_rd(6'h04, v); chk("R1 config", v, 32'h0);
    bus_rd(6'h08, v); chk("R1 mask", v, 32'hFF);
    bus_rd(6'h0C, v); chk("R1 status", v, 32'h0);
    bus_rd(6'h1C, v); chk("R1 bat data", v, 32'h0);
    bus_rd(6'h20, v); chk("R1 aux data", v, 32'h0);

    // R2 map and readback
    bus_wr(6'h04, 32'hA5A5_0001); bus_rd(6'h04, v); chk("R2 config rb", v, 32'hA5A5_0001);
    bus_wr(6'h08, 32'h1234_565A); bus_rd(6'h08, v); chk("R2 mask rb", v, 32'h5A);
    bus_wr(6'h30, 32'hFFFF_FFFF); bus_rd(6'h30, v); chk("R2 unmapped", v, 32'h0);
    bus_wr(6'h08, 32'hFF);

    // R3 R4 R8: aux conversion with exact completion timing, input A
    aux_a = 12'h123; aux_b = 12'hABC;
    bus_wr(6'h04, 32'h1);
    bus_wr(6'h00, 32'h1);
    repeat (LAT - 1) @(negedge clk);
    bus_rd(6'h00, v); chk("R3 busy before end", v, 32'h1);
    bus_rd(6'h00, v); chk("R4 start cleared", v, 32'h0);
    bus_rd(6'h20, v); chk("R8 aux sel A", v, 32'h123);
    bus_rd(6'h0C, v); chk("R5 aux done", v, 32'h1);

    // R8 select B, then code 3 falls back to A
    bus_wr(6'h04, 32'h2); bus_wr(6'h00, 32'h1); wait_idle(0, n);
    bus_rd(6'h20, v); chk("R8 aux sel B", v, 32'hABC);
    aux_a = 12'hFFF;
    bus_wr(6'h04, 32'h3); bus_wr(6'h00, 32'h1); wait_idle(0, n);
    bus_rd(6'h20, v); chk("R8 aux sel code3", v, 32'hFFF);

    // R9 battery
    bat = 12'h7FE;
    bus_wr(6'h00, 32'h2); wait_idle(1, n);
    chk("R4 bat finishes", {31'h0, n > 4 * LAT - 1}, 32'h0);
    bus_rd(6'h1C, v); chk("R9 bat data", v, 32'h7FE);

    // touch engine
    bus_wr(6'h00, 32'h4); wait_idle(2, n);
    bus_rd(6'h0C, v); chk("R5 all engines done", v, 32'h7);

    // R6 write-one-to-clear
    bus_wr(6'h0C, 32'h2); bus_rd(6'h0C, v); chk("R6 clear bat only", v, 32'h5);
    bus_wr(6'h0C, 32'h0); bus_rd(6'h0C, v); chk("R6 zero write no effect", v, 32'h5);

    // R7 interrupt masking
    repeat (2) @(negedge clk);
    chk("R7 all masked", {31'h0, irq}, 32'h0);
    bus_wr(6'h08, 32'hFE);
    @(negedge clk);
    chk("R7 aux unmasked", {31'h0, irq}, 32'h1);
    bus_wr(6'h0C, 32'hFF);
    @(negedge clk);
    chk("R7 cleared drops irq", {31'h0, irq}, 32'h0);

    // R5 events
    evt = 4'hF; @(negedge clk); evt = 4'h0;
    bus_rd(6'h0C, v); chk("R5 event bits", v, 32'hB8);
    bus_wr(6'h08, 32'h7F);
    @(negedge clk);
    chk("R7 sleep irq", {31'h0, irq}, 32'h1);
    bus_wr(6'h0C, 32'hFF);
    bus_wr(6'h08, 32'hFF);

    // R6 set wins over same-cycle clear
    bus_wr(6'h00, 32'h1);
    repeat (LAT - 1) @(negedge clk);
    bus_wr(6'h0C, 32'h1);
    bus_rd(6'h0C, v); chk("R6 set wins", v, 32'h1);
    bus_wr(6'h0C, 32'h1);
    bus_rd(6'h0C, v); chk("R6 plain clear", v, 32'h0);
    bus_rd(6'h20, last_aux);

    // R10 power-down aborts and blocks
    aux_a = 12'h456; bus_wr(6'h04, 32'h1);
    bus_wr(6'h00, 32'h1);
    repeat (2) @(negedge clk);
    bus_wr(6'h00, 32'h80);
    bus_rd(6'h00, v); chk("R10 start aborted", v, 32'h80);
    repeat (LAT + 4) @(negedge clk);
    bus_rd(6'h0C, v); chk("R10 no status", v, 32'h0);
    bus_rd(6'h20, v); chk("R10 data kept", v, last_aux);
    bus_wr(6'h00, 32'h83);
    bus_rd(6'h00, v); chk("R10 start ignored", v, 32'h80);
    repeat (LAT + 4) @(negedge clk);
    bus_rd(6'h0C, v); chk("R10 still idle", v, 32'h0);
    bus_wr(6'h00, 32'h0);
    bus_wr(6'h00, 32'h1); wait_idle(0, n);
    bus_rd(6'h20, v); chk("R10 resumes", v, 32'h456);
    bus_wr(6'h0C, 32'hFF);

    // random conversions
    for (int i = 0; i < 24; i++) begin
      logic [1:0] sel;
      sel = 2'($urandom);
      aux_a = 12'($urandom); aux_b = 12'($urandom); bat = 12'($urandom);
      bus_wr(6'h04, {30'($urandom), sel});
      if ($urandom % 2 == 0) begin
        bus_wr(6'h00, 32'h1); wait_idle(0, n);
        bus_rd(6'h20, v); chk("R8 random aux", v, exp_aux(sel, aux_a, aux_b));
        bus_rd(6'h0C, v); chk("R5 random aux status", v, 32'h1);
      end else begin
        bus_wr(6'h00, 32'h2); wait_idle(1, n);
        bus_rd(6'h1C, v); chk("R9 random bat", v, {20'h0, bat});
        bus_rd(6'h0C, v); chk("R5 random bat status", v, 32'h2);
      end
      bus_wr(6'h0C, 32'hFF);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule